// File: doc/BRIEF.md
# I/Q Interpolate-by-8 FIR Stage

This block sits on a transmit path between a channel splitter and a clock-crossing FIFO. It takes one packed I/Q word per handshake and returns two separate 16-bit channel outputs. The downstream side takes each output sample with a one-cycle read strobe. In filtering mode every accepted input word turns into eight output samples. These come from an 8-phase polyphase lowpass with 128 taps in total. In pass-through mode each read takes one input word unchanged.

The downstream read strobe sets the pace of the whole stage. The input ready is combinational from the read strobe. In filtering mode ready is raised on one read in eight. In pass-through mode it is raised on every read. A single mode bit selects between the two modes. Any change of that bit wipes the sample history and restarts the phase sequence.

The coefficients are a windowed-sinc Nyquist design, computed at elaboration. They are scaled so that each polyphase branch has a DC gain of exactly one. The centre branch is a pure delay. Both channels use the same taps.

Top module: `iq_interp8_fir`

## Requirements
- R1: While reset is active and afterwards, both channel outputs read zero until the first input word has been accepted. A read that finds no valid input leaves them at zero.
- R2: With interp_en = 0, in_ready equals rd_stb. Each read with in_valid high loads ch0_data from in_data[15:0] and ch1_data from in_data[31:16]. The new values are visible in the cycle after the strobe.
- R3: The outputs change only in the cycle after a read strobe. With rd_stb low they hold, whatever in_valid and in_data do, and in_ready stays low.
- R4: With interp_en = 1, in_ready is raised on the first read after reset or after a mode change, and after that on every eighth completed read. A completed read is one that is not stalled.
- R5: A read at a fetch slot with in_valid low is stalled. The outputs and the phase sequence do not change, and the next read is again a fetch slot.
- R6: With interp_en = 1, the output loaded by the read that accepts input word j equals input word j-8 exactly on each channel. Before eight words have been accepted in the current mode, that output is zero.
- R7: With interp_en = 1, once the same value has been fed for 16 consecutive words, all eight outputs per word equal that value exactly. Each channel holds its own value.
- R8: Filter results are rounded to nearest and saturate to the signed 16-bit range. Consider the 16 most recent words, where k = 0 is the newest. Give word k the sign + when (|2k-15|-1)/2 is even and - otherwise, at magnitude 32767. The fifth output of the newest word then reads 32767 on a channel fed with that pattern. On a channel fed with the negated pattern it reads -32768.
- R9: A change of interp_en clears the history. After returning to filtering, the first eight fetch outputs are zero even if earlier data was nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interp_en | input | 1 | 1 = interpolate by 8, 0 = pass-through |
| in_data | input | 32 | Packed input word: channel 0 in [15:0], channel 1 in [31:16] |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Input word is taken this cycle when in_valid is high |
| rd_stb | input | 1 | Downstream takes the current output and requests the next |
| ch0_data | output | 16 | Channel 0 output sample (signed) |
| ch1_data | output | 16 | Channel 1 output sample (signed) |

## Verification
The bench builds the block with its default parameters: 16-bit samples, factor 8, 16 taps per phase, and 18-bit coefficients with 16 fraction bits and rounding on. With factor 8 the exact delay of the centre branch is eight words, and the bench predicts the fetch outputs from its own record of accepted words. The unity gain of every branch makes a DC run exact. The half-way branch has summed tap magnitudes near two, so a sign pattern of 16 words drives it past full scale in both directions.

// File: rtl/iq_interp_pkg.sv
package iq_interp_pkg;

   typedef enum logic {
      MODE_PASS = 1'b0,
      MODE_FILT = 1'b1
   } iq_mode_e;

   localparam int NUM_CH = 2;

   // pi in Q28 and 1/pi in Q20
   localparam longint PI_Q28    = 64'sd843314857;
   localparam longint INVPI_Q20 = 64'sd333772;

   // sine of an angle in [0, pi/2], Q28 in and out, odd Taylor series
   function automatic longint sin_q28(input longint ang);
      longint x2;
      longint term;
      longint acc;
      x2   = (ang * ang) >>> 28;
      term = ang;
      acc  = ang;
      for (int n = 1; n <= 7; n++) begin
         term = -((term * x2) >>> 28) / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

endpackage

// File: rtl/iq_interp_coef.sv
module iq_interp_coef #(
   parameter int INTERP    = 8,
   parameter int TPP       = 16,
   parameter int COEF_W    = 18,
   parameter int COEF_FRAC = 16
) (
   input  logic [((INTERP > 1) ? $clog2(INTERP) : 1)-1:0] phase_i,
   output logic [TPP*COEF_W-1:0]                           taps_o
);
   import iq_interp_pkg::*;

   localparam int NTAPS = INTERP * TPP;
   localparam int CTR   = NTAPS / 2;

   function automatic logic [NTAPS*COEF_W-1:0] build_coefs();
      longint h [NTAPS];
      logic [NTAPS*COEF_W-1:0] v;
      for (int m = 0; m < NTAPS; m++) begin
         longint d, r, r2, s, t, w, w2, w3, p;
         bit neg;
         d = (m > CTR) ? longint'(m - CTR) : longint'(CTR - m);
         if (d == 0) begin
            h[m] = longint'(1) <<< COEF_FRAC;
         end else if (d >= CTR) begin
            h[m] = 0;
         end else begin
            r   = d % longint'(2 * INTERP);
            neg = (r >= INTERP);
            r2  = r % longint'(INTERP);
            if (2 * r2 > INTERP) r2 = longint'(INTERP) - r2;
            s = sin_q28((PI_Q28 * r2) / longint'(INTERP));
            if (neg) s = -s;
            t  = ((longint'(INTERP) * s * INVPI_Q20) >>> 28) / d;
            w  = ((longint'(CTR * CTR) - d * d) <<< 16) / longint'(CTR * CTR);
            w2 = (w * w) >>> 16;
            w3 = (w2 * w) >>> 16;
            p  = t * w3;
            h[m] = (p + (longint'(1) <<< (35 - COEF_FRAC))) >>> (36 - COEF_FRAC);
         end
      end
      // force every branch to sum to exactly one
      for (int ph = 1; ph < INTERP; ph++) begin
         longint sum;
         int idx;
         sum = 0;
         for (int k = 0; k < TPP; k++) sum = sum + h[ph + INTERP * k];
         idx = (2 * ph <= INTERP) ? (CTR + ph) : (CTR - INTERP + ph);
         h[idx] = h[idx] + ((longint'(1) <<< COEF_FRAC) - sum);
      end
      v = '0;
      for (int m = 0; m < NTAPS; m++) v[m*COEF_W +: COEF_W] = h[m][COEF_W-1:0];
      return v;
   endfunction

   localparam logic [NTAPS*COEF_W-1:0] COEF_VEC = build_coefs();

   always_comb begin
      for (int k = 0; k < TPP; k++) begin
         taps_o[k*COEF_W +: COEF_W] = COEF_VEC[(int'(phase_i) + INTERP * k) * COEF_W +: COEF_W];
      end
   end

endmodule

// File: rtl/iq_interp_hist.sv
module iq_interp_hist #(
   parameter int SAMPLE_W = 16,
   parameter int TPP      = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_i,
   input  logic                     clear_i,
   input  logic [SAMPLE_W-1:0]      din_i,
   output logic [TPP*SAMPLE_W-1:0]  view_o
);
   logic [TPP*SAMPLE_W-1:0] hist_q;
   logic [TPP*SAMPLE_W-1:0] base;

   // slot 0 (low bits) is the newest word
   always_comb begin
      base   = clear_i ? '0 : hist_q;
      view_o = shift_i ? {base[(TPP-1)*SAMPLE_W-1:0], din_i} : base;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (shift_i || clear_i) begin
         hist_q <= view_o;
      end
   end

endmodule

// File: rtl/iq_interp_mac.sv
module iq_interp_mac #(
   parameter int SAMPLE_W      = 16,
   parameter int TPP           = 16,
   parameter int COEF_W        = 18,
   parameter int COEF_FRAC     = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [TPP*SAMPLE_W-1:0] samples_i,
   input  logic [TPP*COEF_W-1:0]   taps_i,
   output logic [SAMPLE_W-1:0]     y_o
);
   localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(TPP) + 1;
   localparam logic signed [ACC_W-1:0] MAX_V = (ACC_W'(1) <<< (SAMPLE_W - 1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] MIN_V = -(ACC_W'(1) <<< (SAMPLE_W - 1));

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] scaled;

   always_comb begin
      acc = '0;
      for (int k = 0; k < TPP; k++) begin
         logic signed [SAMPLE_W-1:0] s;
         logic signed [COEF_W-1:0]   c;
         s   = samples_i[k*SAMPLE_W +: SAMPLE_W];
         c   = taps_i[k*COEF_W +: COEF_W];
         acc = acc + ACC_W'(s) * ACC_W'(c);
      end
   end

   generate
      if (ROUND_NEAREST) begin : g_round
         assign biased = acc + (ACC_W'(1) <<< (COEF_FRAC - 1));
      end else begin : g_trunc
         assign biased = acc;
      end
   endgenerate

   assign scaled = biased >>> COEF_FRAC;

   always_comb begin
      if (scaled > MAX_V)      y_o = MAX_V[SAMPLE_W-1:0];
      else if (scaled < MIN_V) y_o = MIN_V[SAMPLE_W-1:0];
      else                     y_o = scaled[SAMPLE_W-1:0];
   end

endmodule

// File: rtl/iq_interp_ctrl.sv
module iq_interp_ctrl #(
   parameter int INTERP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic interp_en_i,
   input  logic rd_stb_i,
   input  logic in_valid_i,
   output logic in_ready_o,
   output logic accept_o,
   output logic load_o,
   output logic clear_o,
   output logic filt_o,
   output logic [((INTERP > 1) ? $clog2(INTERP) : 1)-1:0] phase_o
);
   import iq_interp_pkg::*;

   localparam int PH_W = (INTERP > 1) ? $clog2(INTERP) : 1;
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(INTERP - 1);

   iq_mode_e        mode_q;
   iq_mode_e        mode_d;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] eff_ph;
   logic            fetch_slot;

   assign mode_d     = interp_en_i ? MODE_FILT : MODE_PASS;
   assign clear_o    = (mode_d != mode_q);
   assign eff_ph     = clear_o ? LAST_PH : ph_q;
   assign filt_o     = (mode_d == MODE_FILT);
   assign fetch_slot = !filt_o || (eff_ph == LAST_PH);
   assign in_ready_o = rd_stb_i && fetch_slot;
   assign accept_o   = in_ready_o && in_valid_i;
   assign load_o     = rd_stb_i && (!fetch_slot || in_valid_i);
   assign phase_o    = accept_o ? '0 : (eff_ph + PH_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_PASS;
         ph_q   <= LAST_PH;
      end else begin
         mode_q <= mode_d;
         if (!filt_o)     ph_q <= LAST_PH;
         else if (load_o) ph_q <= phase_o;
         else             ph_q <= eff_ph;
      end
   end

endmodule

// File: rtl/iq_interp8_fir.sv
module iq_interp8_fir #(
   parameter int SAMPLE_W      = 16,
   parameter int INTERP        = 8,
   parameter int TPP           = 16,
   parameter int COEF_W        = 18,
   parameter int COEF_FRAC     = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  interp_en,
   input  logic [2*SAMPLE_W-1:0] in_data,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic                  rd_stb,
   output logic [SAMPLE_W-1:0]   ch0_data,
   output logic [SAMPLE_W-1:0]   ch1_data
);
   import iq_interp_pkg::*;

   localparam int PH_W = (INTERP > 1) ? $clog2(INTERP) : 1;

   if (INTERP < 2) begin : g_bad_interp
      $error("INTERP must be 2 or more");
   end
   if ((TPP < 2) || (TPP % 2 != 0)) begin : g_bad_tpp
      $error("TPP must be even and at least 2");
   end
   if ((COEF_FRAC < 1) || (COEF_FRAC > 20) || (COEF_FRAC > COEF_W - 2)) begin : g_bad_frac
      $error("COEF_FRAC must lie in 1..min(20, COEF_W-2)");
   end
   if (INTERP * TPP > 2048) begin : g_bad_len
      $error("INTERP*TPP too large for the coefficient builder");
   end

   logic            accept;
   logic            load;
   logic            clear;
   logic            filt;
   logic [PH_W-1:0] phase;
   logic [TPP*COEF_W-1:0] taps;

   iq_interp_ctrl #(.INTERP(INTERP)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .interp_en_i (interp_en),
      .rd_stb_i    (rd_stb),
      .in_valid_i  (in_valid),
      .in_ready_o  (in_ready),
      .accept_o    (accept),
      .load_o      (load),
      .clear_o     (clear),
      .filt_o      (filt),
      .phase_o     (phase)
   );

   iq_interp_coef #(
      .INTERP    (INTERP),
      .TPP       (TPP),
      .COEF_W    (COEF_W),
      .COEF_FRAC (COEF_FRAC)
   ) u_coef (
      .phase_i (phase),
      .taps_o  (taps)
   );

   logic [SAMPLE_W-1:0] out_q [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [TPP*SAMPLE_W-1:0] view;
      logic [SAMPLE_W-1:0]     y;
      logic [SAMPLE_W-1:0]     raw;

      assign raw = in_data[c*SAMPLE_W +: SAMPLE_W];

      iq_interp_hist #(.SAMPLE_W(SAMPLE_W), .TPP(TPP)) u_hist (
         .clk     (clk),
         .rst_n   (rst_n),
         .shift_i (accept && filt),
         .clear_i (clear),
         .din_i   (raw),
         .view_o  (view)
      );

      iq_interp_mac #(
         .SAMPLE_W      (SAMPLE_W),
         .TPP           (TPP),
         .COEF_W        (COEF_W),
         .COEF_FRAC     (COEF_FRAC),
         .ROUND_NEAREST (ROUND_NEAREST)
      ) u_mac (
         .samples_i (view),
         .taps_i    (taps),
         .y_o       (y)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q[c] <= '0;
         end else if (load) begin
            out_q[c] <= filt ? y : raw;
         end
      end
   end

   assign ch0_data = out_q[0];
   assign ch1_data = out_q[1];

endmodule

// File: rtl/iq_interp8_fir_chk.sv
module iq_interp8_fir_chk #(
   parameter int SAMPLE_W = 16,
   parameter int INTERP   = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  interp_en,
   input logic [2*SAMPLE_W-1:0] in_data,
   input logic                  in_valid,
   input logic                  in_ready,
   input logic                  rd_stb,
   input logic [SAMPLE_W-1:0]   ch0_data,
   input logic [SAMPLE_W-1:0]   ch1_data
);
   logic prev_mode;
   logic seen_word;
   int   reads_since;
   int   eff_reads;
   logic mode_flip;
   logic stalled;

   assign mode_flip = (interp_en != prev_mode);
   assign eff_reads = mode_flip ? (INTERP - 1) : reads_since;
   assign stalled   = in_ready && !in_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_mode   <= 1'b0;
         seen_word   <= 1'b0;
         reads_since <= INTERP - 1;
      end else begin
         prev_mode <= interp_en;
         if (in_ready && in_valid) seen_word <= 1'b1;
         if (!interp_en)                reads_since <= INTERP - 1;
         else if (rd_stb && !stalled)   reads_since <= in_ready ? 0 : eff_reads + 1;
         else                           reads_since <= eff_reads;
      end
   end

   assert_zero_until_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_word |-> (ch0_data == '0 && ch1_data == '0));

   assert_pass_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!interp_en && rd_stb) |-> in_ready);

   assert_pass_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!interp_en && rd_stb && in_valid) |=>
         (ch0_data == $past(in_data[SAMPLE_W-1:0]) &&
          ch1_data == $past(in_data[2*SAMPLE_W-1:SAMPLE_W])));

   assert_hold_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ($stable(ch0_data) && $stable(ch1_data)));

   assert_ready_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> rd_stb);

   assert_pace_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (interp_en && rd_stb) |-> (in_ready == (eff_reads == INTERP - 1)));

   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |=> ($stable(ch0_data) && $stable(ch1_data)));

endmodule

bind iq_interp8_fir iq_interp8_fir_chk #(
   .SAMPLE_W (SAMPLE_W),
   .INTERP   (INTERP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .interp_en (interp_en),
   .in_data   (in_data),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .rd_stb    (rd_stb),
   .ch0_data  (ch0_data),
   .ch1_data  (ch1_data)
);

// File: tb/iq_interp8_fir_test.sv
module iq_interp8_fir_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        interp_en = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        rd_stb = 1'b0;
   logic [15:0] ch0_data;
   logic [15:0] ch1_data;

   always #4 clk = ~clk;

   iq_interp8_fir uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .interp_en (interp_en),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .rd_stb    (rd_stb),
      .ch0_data  (ch0_data),
      .ch1_data  (ch1_data)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   int    q_e0 [$];
   int    q_e1 [$];
   bit    q_chk [$];
   string q_tag [$];
   int    hist0 [$];
   int    hist1 [$];
   bit    fired = 1'b0;

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: one scoreboard item per read strobe
   always @(posedge clk) fired <= rd_stb;

   always @(negedge clk) begin
      if (fired && q_chk.size() > 0) begin
         int    e0, e1;
         bit    c;
         string t;
         e0 = q_e0.pop_front();
         e1 = q_e1.pop_front();
         c  = q_chk.pop_front();
         t  = q_tag.pop_front();
         if (c) begin
            check_eq({t, " ch0"}, int'($signed(ch0_data)), e0);
            check_eq({t, " ch1"}, int'($signed(ch1_data)), e1);
         end
      end
   end

   task automatic idle(input bit noise);
      @(posedge clk); #2;
      rd_stb   = 1'b0;
      in_valid = noise;
      in_data  = noise ? 32'hA5A5_5A5A : 32'h0;
      #1 check_eq("R3 ready", int'(in_ready), 0);
   endtask

   task automatic do_read(input bit v, input int a, input int b, input bit exp_rdy,
                          input bit chk, input int e0, input int e1,
                          input string tag, input string rtag);
      @(posedge clk); #2;
      rd_stb   = 1'b1;
      in_valid = v;
      in_data  = {16'(b), 16'(a)};
      #1 check_eq({rtag, " ready"}, int'(in_ready), int'(exp_rdy));
      q_e0.push_back(e0);
      q_e1.push_back(e1);
      q_chk.push_back(chk);
      q_tag.push_back(tag);
   endtask

   task automatic stall_read(input string tag, input string rtag);
      int p0, p1;
      @(posedge clk); #1;
      p0 = int'($signed(ch0_data));
      p1 = int'($signed(ch1_data));
      #1;
      rd_stb   = 1'b1;
      in_valid = 1'b0;
      in_data  = 32'h1234_4321;
      #1 check_eq({rtag, " ready"}, int'(in_ready), 1);
      q_e0.push_back(p0);
      q_e1.push_back(p1);
      q_chk.push_back(1'b1);
      q_tag.push_back(tag);
   endtask

   task automatic set_mode(input bit m);
      @(posedge clk); #2;
      rd_stb    = 1'b0;
      in_valid  = 1'b0;
      interp_en = m;
      hist0.delete();
      hist1.delete();
   endtask

   // mode 0: fetch only, 1: all phases equal e, 2: fifth output equals e
   task automatic interp_word(input int a, input int b, input int mode,
                              input int e0, input int e1,
                              input string ftag, input string ptag);
      int n, f0, f1;
      n  = hist0.size();
      f0 = (n >= 8) ? hist0[n-8] : 0;
      f1 = (n >= 8) ? hist1[n-8] : 0;
      do_read(1'b1, a, b, 1'b1, 1'b1, f0, f1, ftag, "R4");
      hist0.push_back(a);
      hist1.push_back(b);
      for (int r = 1; r < 8; r++) begin
         bit c;
         c = (mode == 1) || (mode == 2 && r == 4);
         do_read(1'b0, 0, 0, 1'b0, c, e0, e1, ptag, "R4");
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int s0, s1;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 reset ch0", int'(ch0_data), 0);
      check_eq("R1 reset ch1", int'(ch1_data), 0);
      check_eq("R1 reset ready", int'(in_ready), 0);

      // pass-through mode, no word yet: stalled read keeps zeros
      stall_read("R1 zero before word", "R2");
      do_read(1'b1, 32767, -32768, 1'b1, 1'b1, 32767, -32768, "R2 pass", "R2");
      do_read(1'b1, -5, 1234, 1'b1, 1'b1, -5, 1234, "R2 pass", "R2");
      do_read(1'b1, 100, -200, 1'b1, 1'b1, 100, -200, "R2 pass", "R2");
      // no strobe: inputs toggling must not reach outputs
      idle(1'b1); idle(1'b1); idle(1'b1);
      @(negedge clk);
      check_eq("R3 hold ch0", int'($signed(ch0_data)), 100);
      check_eq("R3 hold ch1", int'($signed(ch1_data)), -200);
      stall_read("R5 pass stall", "R2");

      // filtering: constant run
      set_mode(1'b1);
      for (int j = 0; j < 20; j++) begin
         interp_word(1000, -2500, (j >= 15) ? 1 : 0, 1000, -2500, "R6 fetch", "R7 dc");
      end

      // filtering: varying words, exact 8-word delay on the fetch output
      for (int j = 0; j < 20; j++) begin
         if (j == 10) stall_read("R5 filt stall", "R4");
         if (j == 13) begin
            idle(1'b1); idle(1'b0);
         end
         interp_word(((j * 7919 + 321) % 65536) - 32768,
                     ((j * 4111 + 77) % 65536) - 32768,
                     0, 0, 0, "R6 delay", "R6");
      end

      // saturation pattern
      for (int i = 0; i < 16; i++) begin
         int k, d;
         k  = 15 - i;
         d  = (2 * k - 15 < 0) ? (15 - 2 * k) : (2 * k - 15);
         s0 = (((d - 1) / 2) % 2 == 0) ? 32767 : -32767;
         s1 = -s0;
         interp_word(s0, s1, (i == 15) ? 2 : 0, 32767, -32768, "R6 fetch", "R8 saturate");
      end

      // leave and re-enter filtering: history must be cleared
      set_mode(1'b0);
      set_mode(1'b1);
      for (int j = 0; j < 10; j++) begin
         interp_word(300 + j, -300 - j, 0, 0, 0, (j == 0 || j == 8) ? "R9 clear" : "R6 fetch", "R9");
      end

      idle(1'b0); idle(1'b0); idle(1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule